// File: doc/BRIEF.md
# SD Card SPI Read Token Parser

This block sits on the receive path of an SPI master that reads from an SD card. After the controller issues a single-block or multi-block read command, it pulses `start` and hands over each byte received on the data-in line through `rx_byte` with `rx_valid`. The parser first skips idle bytes until it sees the command response. It then skips `0xFF` filler until the first byte that is not filler. That byte is the start token, and the parser sorts it into one of three classes: a data token, an error token or an illegal byte.

Tokens are found only on byte boundaries, so a run of idle ones followed by a data byte that starts with zero bits cannot be mistaken for an error token. After a data token, the payload bytes and then the CRC bytes are streamed out, each tagged as payload or CRC. In multi-block mode the token search starts again after every block until the controller lowers `multi`. Every transaction ends with a one-cycle `done` pulse and a result code. Separate programmable byte-count limits end a response wait or a token wait that lasts too long.

Result codes on `done_code`: 0 success, 1 response error, 2 error token, 3 illegal token, 4 response timeout, 5 token timeout.

Top module: `sdrd_token_parser`

## Requirements
- R1: After an accepted `start`, bytes with bit 7 set are skipped. The first byte with bit 7 clear is the response: it appears on `r1_byte`, with `r1_valid` high for one cycle, in the cycle after that byte is accepted.
- R2: A non-zero response ends the transaction with `done` and code 1. No token search follows and no data is produced.
- R3: After a zero response, `0xFF` bytes are skipped. The first byte that is not `0xFF` is the start token, and the value `0xFE` starts a data block.
- R4: After a data token, exactly BLOCK_BYTES payload bytes appear on `dout` with `dout_crc` low, then exactly CRC_BYTES bytes with `dout_crc` high. Each one appears with `dout_valid` in the cycle after its input byte is accepted, in input order.
- R5: A start token in the range `0x01` to `0x0F` ends the transaction with code 2, and `err_flags` equals the low four bits of the token.
- R6: Any other start token that is not `0xFF`, `0x00` included, ends the transaction with code 3.
- R7: While waiting for the response, the `r1_limit`-th skipped byte ends the transaction with code 4 and `timeout` high. One skipped byte fewer does not.
- R8: While waiting for a token, the `tok_limit`-th `0xFF` byte ends the transaction with code 5 and `timeout` high.
- R9: When the last CRC byte of a block is accepted and `multi` is high, the token search starts again. When `multi` is low at that byte, `done` with code 0 comes in the same cycle as that CRC byte's output.
- R10: In a token wait that follows a completed block, a low `multi` ends the transaction with code 0 in the next cycle, and any byte offered in that cycle is not consumed.
- R11: `start` has no effect while a transaction is running. Bytes that arrive while the parser is idle produce no output.
- R12: After reset all outputs are zero. `done_code`, `err_flags` and `timeout` hold their values from `done` until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a transaction when idle |
| multi | input | 1 | Multi-block mode; lowered to end the block stream |
| rx_valid | input | 1 | A received byte is present |
| rx_byte | input | 8 | Received byte |
| r1_limit | input | TMO_W | Skipped-byte limit while waiting for the response |
| tok_limit | input | TMO_W | Filler-byte limit while waiting for a token |
| r1_valid | output | 1 | One-cycle pulse: response captured |
| r1_byte | output | 8 | Captured response |
| dout_valid | output | 1 | A payload or CRC byte is on `dout` |
| dout | output | 8 | Forwarded byte |
| dout_crc | output | 1 | The byte on `dout` is a CRC byte |
| done | output | 1 | One-cycle pulse: transaction ended |
| done_code | output | 3 | Result code, held until the next start |
| err_flags | output | 4 | Flags from an error token |
| timeout | output | 1 | The transaction ended on a timeout |

## Verification
The bench builds the parser with BLOCK_BYTES=16, CRC_BYTES=2 and a 6-bit timeout width, and sets both limits to 5 or 6. With a 16-byte block, many complete transactions fit in a short run, and multi-block sequences of three blocks cover both ways of ending the stream. The small limits make both timeouts reachable exactly at the limit and one byte before it. Random filler runs, random response values and random tokens of every class are mixed with directed cases: token `0x00`, fillers other than `0xFF` in the response wait, and `start` pulses in the middle of a block.

// File: rtl/sdrd_pkg.sv
package sdrd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_R1,
        ST_TOK,
        ST_DATA,
        ST_CRC
    } st_e;

    typedef enum logic [2:0] {
        RC_OK     = 3'd0,
        RC_R1ERR  = 3'd1,
        RC_TOKERR = 3'd2,
        RC_PROTO  = 3'd3,
        RC_R1TMO  = 3'd4,
        RC_TOKTMO = 3'd5
    } rc_e;

    localparam logic [7:0] BYTE_IDLE = 8'hFF;
    localparam logic [7:0] BYTE_DTOK = 8'hFE;

    typedef struct packed {
        logic msb_set;   // skipped while waiting for the response
        logic idle;      // exactly 0xFF
        logic resp;      // bit 7 clear
        logic data_tok;  // 0xFE
        logic err_tok;   // 0x01..0x0F
    } cls_t;

    function automatic cls_t classify(input logic [7:0] b);
        cls_t c;
        c.msb_set  = b[7];
        c.idle     = (b == BYTE_IDLE);
        c.resp     = !b[7];
        c.data_tok = (b == BYTE_DTOK);
        c.err_tok  = (b[7:4] == 4'h0) && (b[3:0] != 4'h0);
        return c;
    endfunction

endpackage

// File: rtl/sdrd_classify.sv
module sdrd_classify
    import sdrd_pkg::*;
(
    input  logic [7:0] byte_in,
    output cls_t       cls
);
    always_comb cls = classify(byte_in);
endmodule

// File: rtl/sdrd_count.sv
module sdrd_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] limit,
    output logic         hit,
    output logic [W-1:0] cnt
);
    logic [W:0] nxt;

    always_comb begin
        nxt = {1'b0, cnt} + 1'b1;
        hit = inc && (nxt >= {1'b0, limit});
    end

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (inc)   cnt <= nxt[W-1:0];
    end
endmodule

// File: rtl/sdrd_token_parser.sv
module sdrd_token_parser
    import sdrd_pkg::*;
#(
    parameter int BLOCK_BYTES = 512,
    parameter int CRC_BYTES   = 2,
    parameter int TMO_W       = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             multi,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    input  logic [TMO_W-1:0] r1_limit,
    input  logic [TMO_W-1:0] tok_limit,
    output logic             r1_valid,
    output logic [7:0]       r1_byte,
    output logic             dout_valid,
    output logic [7:0]       dout,
    output logic             dout_crc,
    output logic             done,
    output logic [2:0]       done_code,
    output logic [3:0]       err_flags,
    output logic             timeout
);
    localparam int PW = $clog2(BLOCK_BYTES + 1);
    localparam logic [PW-1:0] BLK_LIM = PW'(BLOCK_BYTES);
    localparam logic [PW-1:0] CRC_LIM = PW'(CRC_BYTES);

    st_e  st;
    cls_t cls;
    logic blk_seen;

    sdrd_classify u_cls (.byte_in(rx_byte), .cls(cls));

    // wait counter, shared by the response wait and the token wait
    logic             w_clr, w_inc, w_hit;
    logic [TMO_W-1:0] w_lim, w_cnt;
    always_comb begin
        w_clr = !(st == ST_R1 || st == ST_TOK) || (st == ST_R1 && rx_valid && cls.resp);
        w_inc = rx_valid && ((st == ST_R1 && cls.msb_set) || (st == ST_TOK && cls.idle));
        w_lim = (st == ST_R1) ? r1_limit : tok_limit;
    end
    sdrd_count #(.W(TMO_W)) u_wait (
        .clk(clk), .rst(rst), .clr(w_clr), .inc(w_inc),
        .limit(w_lim), .hit(w_hit), .cnt(w_cnt)
    );

    // block byte counter, shared by payload and CRC phases
    logic          p_clr, p_inc, p_hit;
    logic [PW-1:0] p_lim, p_cnt;
    always_comb begin
        p_inc = rx_valid && (st == ST_DATA || st == ST_CRC);
        p_clr = !(st == ST_DATA || st == ST_CRC) || p_hit;
        p_lim = (st == ST_DATA) ? BLK_LIM : CRC_LIM;
    end
    sdrd_count #(.W(PW)) u_blk (
        .clk(clk), .rst(rst), .clr(p_clr), .inc(p_inc),
        .limit(p_lim), .hit(p_hit), .cnt(p_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            blk_seen   <= 1'b0;
            r1_valid   <= 1'b0;
            r1_byte    <= '0;
            dout_valid <= 1'b0;
            dout       <= '0;
            dout_crc   <= 1'b0;
            done       <= 1'b0;
            done_code  <= RC_OK;
            err_flags  <= '0;
            timeout    <= 1'b0;
        end else begin
            r1_valid   <= 1'b0;
            dout_valid <= 1'b0;
            dout_crc   <= 1'b0;
            done       <= 1'b0;
            unique case (st)
                ST_IDLE: if (start) begin
                    st        <= ST_R1;
                    blk_seen  <= 1'b0;
                    done_code <= RC_OK;
                    err_flags <= '0;
                    timeout   <= 1'b0;
                end
                ST_R1: if (rx_valid) begin
                    if (cls.resp) begin
                        r1_valid <= 1'b1;
                        r1_byte  <= rx_byte;
                        if (rx_byte != 8'h00) begin
                            st <= ST_IDLE; done <= 1'b1; done_code <= RC_R1ERR;
                        end else begin
                            st <= ST_TOK;
                        end
                    end else if (w_hit) begin
                        st <= ST_IDLE; done <= 1'b1; done_code <= RC_R1TMO; timeout <= 1'b1;
                    end
                end
                ST_TOK: if (blk_seen && !multi) begin
                    st <= ST_IDLE; done <= 1'b1; done_code <= RC_OK;
                end else if (rx_valid) begin
                    if (cls.idle) begin
                        if (w_hit) begin
                            st <= ST_IDLE; done <= 1'b1; done_code <= RC_TOKTMO; timeout <= 1'b1;
                        end
                    end else if (cls.data_tok) begin
                        st <= ST_DATA;
                    end else if (cls.err_tok) begin
                        st <= ST_IDLE; done <= 1'b1; done_code <= RC_TOKERR;
                        err_flags <= rx_byte[3:0];
                    end else begin
                        st <= ST_IDLE; done <= 1'b1; done_code <= RC_PROTO;
                    end
                end
                ST_DATA: if (rx_valid) begin
                    dout       <= rx_byte;
                    dout_valid <= 1'b1;
                    if (p_hit) st <= ST_CRC;
                end
                ST_CRC: if (rx_valid) begin
                    dout       <= rx_byte;
                    dout_valid <= 1'b1;
                    dout_crc   <= 1'b1;
                    if (p_hit) begin
                        if (multi) begin
                            st <= ST_TOK; blk_seen <= 1'b1;
                        end else begin
                            st <= ST_IDLE; done <= 1'b1; done_code <= RC_OK;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R1: a captured response always has bit 7 clear
    a_r1_resp_msb: assert property (@(posedge clk) disable iff (rst)
        r1_valid |-> !r1_byte[7]);
    // R4: CRC marking only accompanies a forwarded byte
    a_r4_crc_with_valid: assert property (@(posedge clk) disable iff (rst)
        dout_crc |-> dout_valid);
    // R4: block counter stays inside the block
    a_r4_blk_bound: assert property (@(posedge clk) disable iff (rst)
        p_cnt < BLK_LIM);
    // R11: nothing is produced in the cycle after a transaction ends
    a_r11_quiet_after_done: assert property (@(posedge clk) disable iff (rst)
        done |=> (!dout_valid && !r1_valid && !done));
    // R7, R8: the timeout flag goes only with a timeout code
    a_r8_timeout_code: assert property (@(posedge clk) disable iff (rst)
        timeout |-> (done_code == RC_R1TMO || done_code == RC_TOKTMO));
    // R5: error flags are non-zero only for an error token
    a_r5_flags_code: assert property (@(posedge clk) disable iff (rst)
        (err_flags != 4'h0) |-> (done_code == RC_TOKERR));
    // R12: result code held while no transaction ends or starts
    a_r12_code_hold: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE && !done) |=> (done || $stable(done_code)));
endmodule

// File: tb/tb_sdrd_token_parser.sv
module tb_sdrd_token_parser;
    localparam int CLK_PERIOD = 10;
    localparam int BLK = 16;
    localparam int CRCN = 2;
    localparam int TW = 6;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0, multi = 1'b0, rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic [TW-1:0] r1_limit = 6'd6, tok_limit = 6'd6;
    logic r1_valid, dout_valid, dout_crc, done, timeout;
    logic [7:0] r1_byte, dout;
    logic [2:0] done_code;
    logic [3:0] err_flags;

    sdrd_token_parser #(.BLOCK_BYTES(BLK), .CRC_BYTES(CRCN), .TMO_W(TW)) dut (
        .clk(clk), .rst(rst), .start(start), .multi(multi), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .r1_limit(r1_limit), .tok_limit(tok_limit),
        .r1_valid(r1_valid), .r1_byte(r1_byte), .dout_valid(dout_valid), .dout(dout),
        .dout_crc(dout_crc), .done(done), .done_code(done_code), .err_flags(err_flags),
        .timeout(timeout)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_err = 0;
    int done_n = 0, r1_n = 0, done_with_crc = 0;
    logic [7:0] r1_last;
    logic [7:0] cap_b[$], exp_b[$];
    logic       cap_c[$], exp_c[$];

    always @(negedge clk) if (!rst) begin
        if (dout_valid) begin cap_b.push_back(dout); cap_c.push_back(dout_crc); end
        if (r1_valid) begin r1_n++; r1_last = r1_byte; end
        if (done) begin done_n++; if (dout_valid && dout_crc) done_with_crc++; end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b, input bit gaps);
        rx_byte = b; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
        if (gaps && $urandom_range(0, 3) == 0) @(negedge clk);
    endtask

    task automatic fills(input int n, input logic [7:0] b);
        for (int i = 0; i < n; i++) send(b, 1'b1);
    endtask

    task automatic begin_txn();
        cap_b.delete(); cap_c.delete(); exp_b.delete(); exp_c.delete();
        done_n = 0; r1_n = 0; done_with_crc = 0;
        start = 1'b1; @(negedge clk); start = 1'b0;
    endtask

    task automatic send_block(input bit pulse_start, input bit drop_before_crc);
        send(8'hFE, 1'b1);
        for (int i = 0; i < BLK; i++) begin
            logic [7:0] b = 8'($urandom);
            exp_b.push_back(b); exp_c.push_back(1'b0);
            send(b, 1'b1);
            if (pulse_start && i == BLK/2) begin start = 1'b1; @(negedge clk); start = 1'b0; end
        end
        if (drop_before_crc) multi = 1'b0;
        for (int i = 0; i < CRCN; i++) begin
            logic [7:0] b = 8'($urandom);
            exp_b.push_back(b); exp_c.push_back(1'b1);
            send(b, 1'b1);
        end
    endtask

    task automatic finish_chk(input string req, input int code, input int flags, input int r1cnt);
        repeat (3) @(negedge clk);
        chk({req, " done count"}, done_n, 1);
        chk({req, " code"}, done_code, code);
        chk({req, " flags"}, err_flags, flags);
        chk({req, " timeout"}, timeout, (code >= 4) ? 1 : 0);
        chk({req, " r1 count"}, r1_n, r1cnt);
        chk({req, " data length"}, cap_b.size(), exp_b.size());
        if (cap_b.size() == exp_b.size())
            for (int i = 0; i < exp_b.size(); i++) begin
                chk({req, " data byte"}, cap_b[i], exp_b[i]);
                chk({req, " crc mark"}, cap_c[i], exp_c[i]);
            end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk("R12 reset done", done, 0);
        chk("R12 reset dout_valid", dout_valid, 0);
        chk("R12 reset r1_valid", r1_valid, 0);
        chk("R12 reset code", done_code, 0);
        chk("R12 reset timeout", timeout, 0);

        // R11: bytes while idle are ignored
        cap_b.delete(); done_n = 0; r1_n = 0;
        send(8'h00, 1'b0); send(8'hFE, 1'b0); fills(4, 8'h5A);
        repeat (2) @(negedge clk);
        chk("R11 idle data", cap_b.size(), 0);
        chk("R11 idle done", done_n, 0);
        chk("R11 idle r1", r1_n, 0);

        // R1 R3 R4: single block, non-0xFF fillers before response
        begin_txn(); fills(3, 8'h80); fills(2, 8'hFF); send(8'h00, 1'b1); fills(3, 8'hFF);
        send_block(1'b0, 1'b0);
        finish_chk("R4 single block", 0, 0, 1);
        chk("R1 response value", r1_last, 8'h00);
        chk("R9 done with last crc", done_with_crc, 1);

        // R12: result held after done
        repeat (5) @(negedge clk);
        chk("R12 code held", done_code, 0);

        // R2: non-zero response
        begin_txn(); fills(2, 8'hFF); send(8'h04, 1'b1); send(8'hFE, 1'b1); fills(3, 8'h11);
        finish_chk("R2 response error", 1, 0, 1);
        chk("R2 response value", r1_last, 8'h04);

        // R5: error token
        begin_txn(); send(8'h00, 1'b1); fills(2, 8'hFF); send(8'h09, 1'b1);
        finish_chk("R5 error token", 2, 9, 1);
        chk("R12 flags held", err_flags, 9);

        // R6: zero token and out-of-range token
        begin_txn(); send(8'h00, 1'b1); send(8'h00, 1'b1);
        finish_chk("R6 zero token", 3, 0, 1);
        begin_txn(); send(8'h00, 1'b1); send(8'h3C, 1'b1);
        finish_chk("R6 bad token", 3, 0, 1);

        // R7: response timeout at the limit, and one below it
        r1_limit = 6'd5;
        begin_txn(); fills(5, 8'hFF);
        finish_chk("R7 response timeout", 4, 0, 0);
        begin_txn(); fills(4, 8'hFF); send(8'h00, 1'b1); send_block(1'b0, 1'b0);
        finish_chk("R7 below limit", 0, 0, 1);

        // R8: token timeout at the limit, and one below it
        tok_limit = 6'd5;
        begin_txn(); send(8'h00, 1'b1); fills(5, 8'hFF);
        finish_chk("R8 token timeout", 5, 0, 1);
        begin_txn(); send(8'h00, 1'b1); fills(4, 8'hFF); send_block(1'b0, 1'b0);
        finish_chk("R8 below limit", 0, 0, 1);

        // R9 R10: three blocks, multi dropped during token wait
        multi = 1'b1;
        begin_txn(); send(8'h00, 1'b1);
        for (int k = 0; k < 3; k++) begin fills(k, 8'hFF); send_block(1'b0, 1'b0); end
        repeat (2) @(negedge clk);
        chk("R9 still running", done_n, 0);
        rx_byte = 8'hFE; rx_valid = 1'b1; multi = 1'b0;
        @(negedge clk); rx_valid = 1'b0;
        finish_chk("R10 multi dropped in wait", 0, 0, 1);

        // R9: multi dropped before last block's CRC
        multi = 1'b1;
        begin_txn(); send(8'h00, 1'b1); send_block(1'b0, 1'b0); fills(2, 8'hFF);
        send_block(1'b0, 1'b1);
        finish_chk("R9 multi dropped at crc", 0, 0, 1);
        chk("R9 done with last crc", done_with_crc, 1);

        // R11: start during a block has no effect
        begin_txn(); send(8'h00, 1'b1); send_block(1'b1, 1'b0);
        finish_chk("R11 start while busy", 0, 0, 1);

        // random mix: R1 R2 R3 R5 R6
        r1_limit = 6'd6; tok_limit = 6'd6;
        for (int it = 0; it < 24; it++) begin
            int kind = $urandom_range(0, 3);
            logic [7:0] tok;
            begin_txn();
            fills($urandom_range(0, 4), 8'hFF);
            if (kind == 3) begin
                logic [7:0] r = 8'($urandom_range(1, 127));
                send(r, 1'b1);
                finish_chk("R2 random response", 1, 0, 1);
                chk("R1 random response value", r1_last, r);
            end else begin
                send(8'h00, 1'b1);
                fills($urandom_range(0, 4), 8'hFF);
                if (kind == 0) begin
                    send_block(1'b0, 1'b0);
                    finish_chk("R3 random data", 0, 0, 1);
                end else if (kind == 1) begin
                    tok = 8'($urandom_range(1, 15));
                    send(tok, 1'b1);
                    finish_chk("R5 random error token", 2, int'(tok[3:0]), 1);
                end else begin
                    tok = 8'($urandom_range(16, 253));
                    send(tok, 1'b1);
                    finish_chk("R6 random bad token", 3, 0, 1);
                end
            end
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule